// File: doc/BRIEF.md
# Output Short and Overload Monitor

This block supervises one regulator channel. It watches two one-bit comparator results: one says the output sits below its low threshold, and one says the current limiter is active. It qualifies both with timers that advance on a one-microsecond timebase tick. When the output is judged shorted or overloaded, the block raises a latched request that shuts down the converter core and emits a one-cycle short-circuit event for the interrupt logic. A persistent current limit is reported as a debounced level and a one-cycle event, but that report leaves the channel running.

The output check works differently in two phases. At start-up the block makes a single check, exactly one millisecond after the channel is enabled. Once the channel is running it monitors continuously and requires the low condition to last a full millisecond without a break. The current-limit filter uses a much shorter 20 µs window. The analog comparators and the interrupt register file sit outside this block.

Top module: `out_short_mon`

## Requirements
- R1: After reset, `core_off`, `sc_evt`, `ilim_level` and `ilim_evt` are all 0.
- R2: In the start-up phase that follows enable, the block samples `vout_low` once, on the 1000th `us_tick` after enable. If `vout_low` is 1 on that tick, a fault is declared. Values of `vout_low` on earlier ticks have no effect.
- R3: If `vout_low` is 0 on the 1000th start-up tick, no fault is declared and the channel moves into the operating phase.
- R4: In the operating phase, 1000 consecutive `us_tick`s with `vout_low` = 1 declare an overload fault. `core_off` rises on the clock after the deciding tick.
- R5: In the operating phase, a tick with `vout_low` = 0 restarts the 1000-tick overload window.
- R6: `core_off` stays at 1 while `chan_en` is 1. It returns to 0 on the clock after `chan_en` is sampled at 0. A later enable starts a new start-up check.
- R7: `sc_evt` is a single-cycle pulse. It is issued in the first cycle of `core_off` for every declared fault.
- R8: Deasserting `chan_en` cancels any pending start-up check or overload window. After re-enable, a full 1000 ticks are needed again.
- R9: `ilim_level` rises on the clock after the 20th consecutive tick with `ilim_raw` = 1. `ilim_evt` pulses for one cycle at the same time. `ilim_level` falls on the clock after `ilim_raw` is sampled at 0. A drop of `ilim_raw` restarts the 20-tick count.
- R10: The current-limit report has no effect on `core_off`.
- R11: The timers advance only in cycles where `us_tick` is 1. With no tick, no fault and no current-limit report can arise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| vout_low | input | 1 | Output-below-threshold comparator result (1 = low) |
| ilim_raw | input | 1 | Current-limit comparator result (1 = limiting) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| core_off | output | 1 | Latched request to disable the converter core |
| sc_evt | output | 1 | One-cycle short-circuit/overload event |
| ilim_level | output | 1 | Debounced current-limit level |
| ilim_evt | output | 1 | One-cycle pulse when `ilim_level` asserts |

## Verification
A wrong phase state, such as a start-up check that keeps monitoring or an operating phase that never restarts its window, shows up at `core_off` on the exact clock after the 1000th relevant tick: either a fault appears one tick too early or late, or it is missing. A counter that is not cleared on disable or on a comparator drop moves the fault earlier than the count from the latest restart point. The bench therefore checks `core_off` one tick before and at the deciding tick. A stuck event flop shows as extra or missing `sc_evt`/`ilim_evt` pulses against the expected queue within one cycle.

// File: rtl/osm_pkg.sv
// Package: shared types and constants for the output short/overload monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package osm_pkg;

    // Phase of the output supervisor.
    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,
        PH_STARTUP = 2'd1,
        PH_RUN     = 2'd2,
        PH_FAULT   = 2'd3
    } osm_phase_t;

endpackage

// File: rtl/osm_tick_timer.sv
// Module: tick-driven window counter.
// Counts cycles where inc is high, clears on clr, and flags the increment
// that completes LIMIT counted ticks. Holds at LIMIT-1 so it never wraps.
// Assumes: LIMIT >= 2; clr has priority over inc.
module osm_tick_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic expire
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count qualified ticks, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The tick that lands on the last value completes the window.
    always_comb begin
        expire = inc && (cnt == LAST);
    end
endmodule

// File: rtl/osm_out_supervisor.sv
// Module: output supervisor state machine.
// Performs a single check of the low-output flag at the end of the start-up
// window, then debounces it continuously while running. A fault latches
// core_off until enable drops, and issues a one-cycle event.
// Assumes: vout_low is already synchronous to clk.
module osm_out_supervisor
    import osm_pkg::*;
#(
    parameter int WIN_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic vout_low,
    input  logic us_tick,
    output logic core_off,
    output logic sc_evt
);
    osm_phase_t phase_q, phase_d;
    logic       tmr_clr, tmr_inc, tmr_exp;
    logic       evt_q;

    osm_tick_timer #(.LIMIT(WIN_TICKS)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .inc    (tmr_inc),
        .expire (tmr_exp)
    );

    // Next phase and timer control from the current phase.
    always_comb begin
        phase_d = phase_q;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        unique case (phase_q)
            PH_OFF: begin
                tmr_clr = 1'b1;
                if (chan_en) phase_d = PH_STARTUP;
            end
            PH_STARTUP: begin
                tmr_inc = us_tick;
                if (tmr_exp) begin
                    tmr_clr = 1'b1;
                    phase_d = vout_low ? PH_FAULT : PH_RUN;
                end
            end
            PH_RUN: begin
                tmr_inc = us_tick && vout_low;
                tmr_clr = !vout_low;
                if (tmr_exp) begin
                    tmr_clr = 1'b1;
                    phase_d = PH_FAULT;
                end
            end
            PH_FAULT: begin
                tmr_clr = 1'b1;
            end
            default: begin
                tmr_clr = 1'b1;
                phase_d = PH_OFF;
            end
        endcase
        if (!chan_en) begin
            tmr_clr = 1'b1;
            phase_d = PH_OFF;
        end
    end

    // Phase register and single-cycle fault event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            evt_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            evt_q   <= (phase_d == PH_FAULT) && (phase_q != PH_FAULT);
        end
    end

    // Drive outputs from registered state.
    always_comb begin
        core_off = (phase_q == PH_FAULT);
        sc_evt   = evt_q;
    end
endmodule

// File: rtl/osm_ilim_filter.sv
// Module: current-limit debounce filter.
// Reports a level once ilim_raw has held for ILIM_TICKS consecutive ticks,
// plus a one-cycle event on assertion. The level drops one clock after
// ilim_raw is seen low.
// Assumes: ilim_raw is already synchronous to clk.
module osm_ilim_filter #(
    parameter int ILIM_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim_raw,
    input  logic us_tick,
    output logic ilim_level,
    output logic ilim_evt
);
    logic tmr_exp;
    logic lvl_q, evt_q;
    logic tmr_clr, tmr_inc;

    // Timer control: run on ticks while limiting, restart on release.
    always_comb begin
        tmr_clr = !ilim_raw;
        tmr_inc = us_tick && ilim_raw;
    end

    osm_tick_timer #(.LIMIT(ILIM_TICKS)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .inc    (tmr_inc),
        .expire (tmr_exp)
    );

    // Level and assertion event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            lvl_q <= ilim_raw && (lvl_q || tmr_exp);
            evt_q <= ilim_raw && tmr_exp && !lvl_q;
        end
    end

    // Drive outputs.
    always_comb begin
        ilim_level = lvl_q;
        ilim_evt   = evt_q;
    end
endmodule

// File: rtl/out_short_mon.sv
// Module: top of the per-channel output short and overload monitor.
// Combines the output supervisor and the current-limit filter.
// Assumes: us_tick is one clk cycle wide, once per microsecond.
module out_short_mon #(
    parameter int WIN_TICKS  = 1000,
    parameter int ILIM_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic vout_low,
    input  logic ilim_raw,
    input  logic us_tick,
    output logic core_off,
    output logic sc_evt,
    output logic ilim_level,
    output logic ilim_evt
);
    osm_out_supervisor #(.WIN_TICKS(WIN_TICKS)) u_sup (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .vout_low (vout_low),
        .us_tick  (us_tick),
        .core_off (core_off),
        .sc_evt   (sc_evt)
    );

    osm_ilim_filter #(.ILIM_TICKS(ILIM_TICKS)) u_ilim (
        .clk        (clk),
        .rst_n      (rst_n),
        .ilim_raw   (ilim_raw),
        .us_tick    (us_tick),
        .ilim_level (ilim_level),
        .ilim_evt   (ilim_evt)
    );
endmodule

// File: rtl/out_short_mon_chk.sv
// Checker: port-level properties of out_short_mon, bound to every instance.
module out_short_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic ilim_raw,
    input logic us_tick,
    input logic core_off,
    input logic sc_evt,
    input logic ilim_level,
    input logic ilim_evt
);
    a_r7_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        sc_evt |=> !sc_evt);
    a_r7_evt_with_off: assert property (@(posedge clk) disable iff (!rst_n)
        sc_evt |-> core_off);
    a_r6_off_held: assert property (@(posedge clk) disable iff (!rst_n)
        (core_off && chan_en) |=> core_off);
    a_r6_off_release: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !core_off);
    a_r9_evt_level: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_evt |-> ilim_level);
    a_r9_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !ilim_raw |=> !ilim_level);
    a_r11_no_tick_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !core_off) |=> !core_off);
    a_r11_no_tick_ilim: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !ilim_level) |=> !ilim_level);
endmodule

bind out_short_mon out_short_mon_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .ilim_raw   (ilim_raw),
    .us_tick    (us_tick),
    .core_off   (core_off),
    .sc_evt     (sc_evt),
    .ilim_level (ilim_level),
    .ilim_evt   (ilim_evt)
);

// File: tb/test_out_short_mon.sv
module test_out_short_mon;
    localparam int EV_SC   = 1;
    localparam int EV_ILIM = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_en = 1'b0;
    logic vout_low = 1'b0;
    logic ilim_raw = 1'b0;
    logic us_tick = 1'b0;
    logic core_off, sc_evt, ilim_level, ilim_evt;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    out_short_mon i_out_short_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .vout_low   (vout_low),
        .ilim_raw   (ilim_raw),
        .us_tick    (us_tick),
        .core_off   (core_off),
        .sc_evt     (sc_evt),
        .ilim_level (ilim_level),
        .ilim_evt   (ilim_evt)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic expect_ev(input int kind);
        exp_q.push_back(kind);
    endtask

    task automatic cycle_en;
        chan_en = 1'b0;
        @(negedge clk);
        chan_en = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: pops an expected event for each pulse seen (R7, R9).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sc_evt) begin
                n_cmp++;
                if (exp_q.size() == 0 || exp_q[0] != EV_SC) begin
                    n_bad++;
                    $display("FAIL R7: actual sc_evt pulse, expected %0d at %0t",
                             (exp_q.size() == 0) ? 0 : exp_q[0], $time);
                end
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            if (ilim_evt) begin
                n_cmp++;
                if (exp_q.size() == 0 || exp_q[0] != EV_ILIM) begin
                    n_bad++;
                    $display("FAIL R9: actual ilim_evt pulse, expected %0d at %0t",
                             (exp_q.size() == 0) ? 0 : exp_q[0], $time);
                end
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", core_off, 1'b0);
        check("R1", sc_evt, 1'b0);
        check("R1", ilim_level, 1'b0);
        check("R1", ilim_evt, 1'b0);

        // R2: single check at tick 1000, earlier highs ignored
        vout_low = 1'b1; chan_en = 1'b1;
        @(negedge clk);
        tick_n(300); vout_low = 1'b0; tick_n(200); vout_low = 1'b1; tick_n(499);
        check("R2", core_off, 1'b0);
        expect_ev(EV_SC);
        tick_n(1);
        check("R2", core_off, 1'b1);

        // R6: latched until enable drops
        vout_low = 1'b0;
        tick_n(50);
        check("R6", core_off, 1'b1);
        chan_en = 1'b0;
        @(negedge clk);
        check("R6", core_off, 1'b0);

        // R3: start-up passes
        chan_en = 1'b1; vout_low = 1'b1;
        @(negedge clk);
        tick_n(999); vout_low = 1'b0; tick_n(1);
        check("R3", core_off, 1'b0);

        // R5: restart on a good tick, then R4 overload
        vout_low = 1'b1; tick_n(999); vout_low = 1'b0; tick_n(1);
        check("R5", core_off, 1'b0);
        vout_low = 1'b1; tick_n(999);
        check("R5", core_off, 1'b0);
        expect_ev(EV_SC);
        tick_n(1);
        check("R4", core_off, 1'b1);

        // R8: disable cancels the pending start-up window
        cycle_en();
        tick_n(600);
        chan_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chan_en = 1'b1;
        @(negedge clk);
        tick_n(600);
        check("R8", core_off, 1'b0);
        tick_n(399);
        check("R8", core_off, 1'b0);
        expect_ev(EV_SC);
        tick_n(1);
        check("R8", core_off, 1'b1);

        // R11: no progress without ticks
        cycle_en();
        tick_n(999);
        repeat (3000) @(negedge clk);
        check("R11", core_off, 1'b0);
        expect_ev(EV_SC);
        tick_n(1);
        check("R11", core_off, 1'b1);

        // R9, R10: current-limit debounce
        vout_low = 1'b0;
        cycle_en();
        ilim_raw = 1'b1;
        tick_n(19);
        check("R9", ilim_level, 1'b0);
        expect_ev(EV_ILIM);
        tick_n(1);
        check("R9", ilim_level, 1'b1);
        check("R10", core_off, 1'b0);
        tick_n(30);
        check("R9", ilim_level, 1'b1);
        check("R10", core_off, 1'b0);
        ilim_raw = 1'b0;
        @(negedge clk);
        check("R9", ilim_level, 1'b0);
        ilim_raw = 1'b1; tick_n(10);
        ilim_raw = 1'b0; tick_n(1);
        ilim_raw = 1'b1; tick_n(19);
        check("R9", ilim_level, 1'b0);
        expect_ev(EV_ILIM);
        tick_n(1);
        check("R9", ilim_level, 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7: actual %0d events pending, expected 0", exp_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule